// File: doc/BRIEF.md
# Variable-Rate Playback Request and Capture Tag Generator

This block sits beside the frame parser of a serial audio codec link that runs at a fixed 48 kHz frame rate. At every frame strobe it decides whether the playback slots must carry a new PCM sample in the next controller-to-codec frame. It reports that decision as active-low request flags packed into the status word of the codec-to-controller frame. On the following strobe it compares the previous requests with the tag bits of the arriving frame. It writes accepted samples into the DAC FIFO and records the missed ones.

Two programmable rate registers, one for playback and one for capture, each drive a phase accumulator. Each frame the accumulator adds the programmed rate and wraps at 48000, so its overflow frames mark the sample instants. With the variable-rate enable cleared, the block falls back to one sample on every frame and holds both rate registers at 48000 (0xBB80). The DAC FIFO fill level can veto a request or force one, so the FIFO neither overflows nor runs dry.

Top module: `vra_slot_req`

## Requirements
- R1: After reset the enable is 0, both rate outputs read 48000, `slot1_flags` reads 0x00FFC (no request), `cap_tag`, `fifo_wr`, `underrun` and `miss_count` read 0.
- R2: With the enable at 0, every frame strobe requests every playback slot and sets the tag of every capture slot, whatever the FIFO level is.
- R3: Write address 0 sets the enable from `wr_data[0]`. While the enable is 0, rate writes are ignored. Clearing the enable forces both rates back to 48000 within two cycles.
- R4: With the enable at 1, a write to address 1 sets the playback rate and a write to address 2 sets the capture rate. A value above 48000 is stored as 48000.
- R5: With the enable at 1, each channel adds its rate to an accumulator at every strobe. A sum of 48000 or more subtracts 48000 and marks a sample frame, so rate 48000 gives a sample on every frame and rate 0 gives none.
- R6: Request flags are active low. The flag for slot 3+k sits at bit 11-k of `slot1_flags`. Slots without a request read 1, and bits 19..12 and 1..0 read 0.
- R7: With the enable at 1 and the FIFO level at least FIFO_DEPTH, no playback request is made. A level of 0 always requests. Otherwise the playback sample frames of R5 request.
- R8: At the strobe after a request, each requested slot whose `out_tag` bit (bit k = slot 3+k) is 1 gives a one-cycle `fifo_wr` pulse on bit k. Tags of slots that were not requested have no effect.
- R9: A requested slot whose tag is 0 gives no write. It sets the sticky `underrun` and adds one to `miss_count`, which saturates.
- R10: With the enable at 1, capture slots carry a set `cap_tag` bit only in capture sample frames of R5. In other frames their tags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle strobe at each frame boundary |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 playback rate, 2 capture rate |
| wr_data | input | 16 | Write data |
| fifo_level | input | 5 | DAC FIFO fill level |
| out_tag | input | 10 | Tag bits of the arriving frame, bit k for slot 3+k |
| var_rate_en | output | 1 | Variable-rate enable |
| dac_rate | output | 16 | Playback rate register |
| adc_rate | output | 16 | Capture rate register |
| slot1_flags | output | 20 | Status word carrying active-low request flags |
| cap_tag | output | 10 | Capture tag bits, bit k for slot 3+k |
| fifo_wr | output | 10 | Per-slot FIFO write pulse |
| underrun | output | 1 | Sticky missed-sample flag |
| miss_count | output | 8 | Saturating missed-sample count |

## Verification
The hardest states to reach are those where the accumulator phase meets a FIFO edge. One case is a sample frame that falls while the FIFO is full. The other is a non-sample frame while it is empty. Long random runs at uneven rates such as 44100 and 11025 reach these states, with FIFO levels drawn from a distribution weighted toward 0 and FIFO_DEPTH. A missed tag needs a request outstanding and then a cleared tag, so the stimulus drops tag bits at random and also sets tags for slots that were never requested.

// File: rtl/vra_pkg.sv
package vra_pkg;
   localparam int NUM_SLOTS  = 10;      // slots 3 .. 12
   localparam int FLAG_LSB   = 2;       // slot 12 flag position
   localparam int WORD_W     = 20;
   localparam int FRAME_RATE = 48000;

   typedef enum logic [1:0] {
      ADDR_CTRL = 2'd0,
      ADDR_DAC  = 2'd1,
      ADDR_ADC  = 2'd2
   } vra_addr_e;
endpackage

// File: rtl/vra_cfg_regs.sv
module vra_cfg_regs
   import vra_pkg::*;
#(
   parameter int RATE_W = 16,
   parameter int BASE   = FRAME_RATE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [RATE_W-1:0] wr_data,
   output logic              en,
   output logic [RATE_W-1:0] rate [2]
);
   localparam logic [RATE_W-1:0] BASE_V = RATE_W'(BASE);

   if (BASE >= (1 << RATE_W)) begin : g_bad_width
      $error("rate width too small for base rate");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en <= 1'b0;
      else if (wr_en && wr_addr == ADDR_CTRL)
         en <= wr_data[0];
   end

   for (genvar ch = 0; ch < 2; ch++) begin : g_rate
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rate[ch] <= BASE_V;
         else if (!en)
            rate[ch] <= BASE_V;
         else if (wr_en && wr_addr == 2'(ch + 1))
            rate[ch] <= (wr_data > BASE_V) ? BASE_V : wr_data;
      end
   end
endmodule

// File: rtl/vra_phase_acc.sv
module vra_phase_acc
   import vra_pkg::*;
#(
   parameter int RATE_W = 16,
   parameter int BASE   = FRAME_RATE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              en,
   input  logic [RATE_W-1:0] rate,
   output logic              ev
);
   localparam int ACC_W = RATE_W + 1;
   localparam logic [ACC_W-1:0] BASE_A = ACC_W'(BASE);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] sum;
   logic             hit;

   always_comb begin
      sum = acc_q + ACC_W'(rate);
      hit = (sum >= BASE_A);
      ev  = !en || hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= '0;
      else if (!en)
         acc_q <= '0;
      else if (tick)
         acc_q <= hit ? (sum - BASE_A) : sum;
   end
endmodule

// File: rtl/vra_req_core.sv
module vra_req_core
   import vra_pkg::*;
#(
   parameter int                   LVL_W      = 5,
   parameter int                   FIFO_DEPTH = 16,
   parameter int                   MISS_W     = 8,
   parameter logic [NUM_SLOTS-1:0] PLAY_MASK  = 10'b00_0000_0011,
   parameter logic [NUM_SLOTS-1:0] CAP_MASK   = 10'b00_0000_0011
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 en,
   input  logic                 play_ev,
   input  logic                 cap_ev,
   input  logic [LVL_W-1:0]     fifo_level,
   input  logic [NUM_SLOTS-1:0] out_tag,
   output logic [WORD_W-1:0]    slot1_flags,
   output logic [NUM_SLOTS-1:0] cap_tag,
   output logic [NUM_SLOTS-1:0] fifo_wr,
   output logic                 underrun,
   output logic [MISS_W-1:0]    miss_count
);
   localparam int MISS_MAX = (1 << MISS_W) - 1;

   if (FIFO_DEPTH >= (1 << LVL_W)) begin : g_bad_lvl
      $error("level width cannot represent FIFO_DEPTH");
   end
   if (PLAY_MASK == '0) begin : g_bad_mask
      $error("at least one playback slot required");
   end

   logic [NUM_SLOTS-1:0] req_q, got, miss;
   logic                 full, empty, play_now, cap_now;
   int unsigned          miss_nxt;

   always_comb begin
      full     = (int'(fifo_level) >= FIFO_DEPTH);
      empty    = (fifo_level == '0);
      play_now = !en || (!full && (empty || play_ev));
      cap_now  = !en || cap_ev;
      got      = req_q & out_tag;
      miss     = req_q & ~out_tag;
      miss_nxt = int'(miss_count) + $countones(miss);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q      <= '0;
         cap_tag    <= '0;
         fifo_wr    <= '0;
         underrun   <= 1'b0;
         miss_count <= '0;
      end else begin
         fifo_wr <= '0;
         if (tick) begin
            req_q   <= play_now ? PLAY_MASK : '0;
            cap_tag <= cap_now ? CAP_MASK : '0;
            fifo_wr <= got;
            if (miss != '0) underrun <= 1'b1;
            miss_count <= (miss_nxt > MISS_MAX) ? MISS_W'(MISS_MAX)
                                                : MISS_W'(miss_nxt);
         end
      end
   end

   // slot 3 lands on the highest flag bit, slot 12 on the lowest
   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_flag
      assign slot1_flags[FLAG_LSB + NUM_SLOTS - 1 - k] = ~req_q[k];
   end
   assign slot1_flags[FLAG_LSB-1:0] = '0;
   assign slot1_flags[WORD_W-1:FLAG_LSB+NUM_SLOTS] = '0;
endmodule

// File: rtl/vra_slot_req.sv
module vra_slot_req
   import vra_pkg::*;
#(
   parameter int                   RATE_W     = 16,
   parameter int                   LVL_W      = 5,
   parameter int                   FIFO_DEPTH = 16,
   parameter int                   MISS_W     = 8,
   parameter logic [NUM_SLOTS-1:0] PLAY_MASK  = 10'b00_0000_0011,
   parameter logic [NUM_SLOTS-1:0] CAP_MASK   = 10'b00_0000_0011
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_start,
   input  logic                 wr_en,
   input  logic [1:0]           wr_addr,
   input  logic [RATE_W-1:0]    wr_data,
   input  logic [LVL_W-1:0]     fifo_level,
   input  logic [NUM_SLOTS-1:0] out_tag,
   output logic                 var_rate_en,
   output logic [RATE_W-1:0]    dac_rate,
   output logic [RATE_W-1:0]    adc_rate,
   output logic [WORD_W-1:0]    slot1_flags,
   output logic [NUM_SLOTS-1:0] cap_tag,
   output logic [NUM_SLOTS-1:0] fifo_wr,
   output logic                 underrun,
   output logic [MISS_W-1:0]    miss_count
);
   logic [RATE_W-1:0] rate [2];
   logic [1:0]        ev;

   vra_cfg_regs #(.RATE_W(RATE_W), .BASE(FRAME_RATE)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .en(var_rate_en), .rate(rate)
   );

   for (genvar ch = 0; ch < 2; ch++) begin : g_acc
      vra_phase_acc #(.RATE_W(RATE_W), .BASE(FRAME_RATE)) u_acc (
         .clk(clk), .rst_n(rst_n), .tick(frame_start), .en(var_rate_en),
         .rate(rate[ch]), .ev(ev[ch])
      );
   end

   vra_req_core #(
      .LVL_W(LVL_W), .FIFO_DEPTH(FIFO_DEPTH), .MISS_W(MISS_W),
      .PLAY_MASK(PLAY_MASK), .CAP_MASK(CAP_MASK)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .tick(frame_start), .en(var_rate_en),
      .play_ev(ev[0]), .cap_ev(ev[1]), .fifo_level(fifo_level),
      .out_tag(out_tag), .slot1_flags(slot1_flags), .cap_tag(cap_tag),
      .fifo_wr(fifo_wr), .underrun(underrun), .miss_count(miss_count)
   );

   assign dac_rate = rate[0];
   assign adc_rate = rate[1];
endmodule

// File: rtl/vra_slot_req_chk.sv
module vra_slot_req_chk
   import vra_pkg::*;
#(
   parameter int                   RATE_W     = 16,
   parameter int                   LVL_W      = 5,
   parameter int                   FIFO_DEPTH = 16,
   parameter logic [NUM_SLOTS-1:0] PLAY_MASK  = 10'b00_0000_0011
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 frame_start,
   input logic [LVL_W-1:0]     fifo_level,
   input logic                 var_rate_en,
   input logic [RATE_W-1:0]    dac_rate,
   input logic [RATE_W-1:0]    adc_rate,
   input logic [WORD_W-1:0]    slot1_flags,
   input logic [NUM_SLOTS-1:0] fifo_wr,
   input logic                 underrun
);
   logic [NUM_SLOTS-1:0] req_seen;
   always_comb
      for (int k = 0; k < NUM_SLOTS; k++)
         req_seen[k] = ~slot1_flags[FLAG_LSB + NUM_SLOTS - 1 - k];

   // R3: a disabled block holds the fixed frame rate
   a_r3_forced_rate: assert property (@(posedge clk) disable iff (!rst_n)
      (!var_rate_en && $past(!var_rate_en)) |->
         (int'(dac_rate) == FRAME_RATE && int'(adc_rate) == FRAME_RATE));

   // R4: stored rates never exceed the frame rate
   a_r4_rate_cap: assert property (@(posedge clk) disable iff (!rst_n)
      int'(dac_rate) <= FRAME_RATE && int'(adc_rate) <= FRAME_RATE);

   // R7: a full FIFO blocks every playback request
   a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && var_rate_en && int'(fifo_level) >= FIFO_DEPTH)
         |=> ((req_seen & PLAY_MASK) == '0));

   // R8: writes only for slots requested before the strobe
   a_r8_wr_requested: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr != '0) |-> ((fifo_wr & ~$past(req_seen)) == '0));

   // R8: writes follow a frame strobe
   a_r8_wr_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr != '0) |-> $past(frame_start));

   // R9: underrun stays set
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(underrun) |-> underrun);

   // R6: reserved bits of the status word stay clear
   a_r6_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_start) |=>
         (slot1_flags[FLAG_LSB-1:0] == '0 &&
          slot1_flags[WORD_W-1:FLAG_LSB+NUM_SLOTS] == '0));
endmodule

bind vra_slot_req vra_slot_req_chk #(
   .RATE_W(RATE_W), .LVL_W(LVL_W), .FIFO_DEPTH(FIFO_DEPTH), .PLAY_MASK(PLAY_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .fifo_level(fifo_level),
   .var_rate_en(var_rate_en), .dac_rate(dac_rate), .adc_rate(adc_rate),
   .slot1_flags(slot1_flags), .fifo_wr(fifo_wr), .underrun(underrun)
);

// File: tb/sim_vra_slot_req.sv
module sim_vra_slot_req;
   localparam int BASE  = 48000;
   localparam int DEPTH = 16;
   localparam logic [9:0] PMASK = 10'b00_0000_0011;
   localparam logic [9:0] CMASK = 10'b00_0000_0011;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [4:0]  fifo_level = 5'd8;
   logic [9:0]  out_tag = '0;
   logic        var_rate_en;
   logic [15:0] dac_rate, adc_rate;
   logic [19:0] slot1_flags;
   logic [9:0]  cap_tag, fifo_wr;
   logic        underrun;
   logic [7:0]  miss_count;

   int n_chk = 0, n_bad = 0;

   // bench model of the requirements
   int   m_en = 0, m_rate[2] = '{BASE, BASE}, m_acc[2] = '{0, 0};
   logic [9:0] m_req = '0, m_cap = '0, m_wr = '0;
   int   m_under = 0, m_miss = 0;
   int   play_frames = 0;

   always #2 clk = ~clk;

   vra_slot_req u0 (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .fifo_level(fifo_level),
      .out_tag(out_tag), .var_rate_en(var_rate_en), .dac_rate(dac_rate),
      .adc_rate(adc_rate), .slot1_flags(slot1_flags), .cap_tag(cap_tag),
      .fifo_wr(fifo_wr), .underrun(underrun), .miss_count(miss_count)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int flags_of(input logic [9:0] req);
      int w = 0;
      for (int k = 0; k < 10; k++)
         if (!req[k]) w |= (1 << (11 - k));
      return w;
   endfunction

   function automatic int step_acc(input int ch);
      int s;
      if (m_en == 0) begin m_acc[ch] = 0; return 1; end
      s = m_acc[ch] + m_rate[ch];
      if (s >= BASE) begin m_acc[ch] = s - BASE; return 1; end
      m_acc[ch] = s;
      return 0;
   endfunction

   task automatic write(input logic [1:0] a, input int d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
      @(negedge clk); wr_en = 1'b0;
      @(negedge clk);
      if (a == 2'd0) begin
         m_en = d & 1;
         if (m_en == 0) begin
            m_rate = '{BASE, BASE}; m_acc = '{0, 0};
         end
      end else if (m_en != 0) begin
         m_rate[a-1] = (d > BASE) ? BASE : d;
      end
   endtask

   task automatic frame(input logic [9:0] tag, input int lvl, input string tagr);
      int pe, ce, n;
      @(negedge clk);
      frame_start = 1'b1; out_tag = tag; fifo_level = 5'(lvl);
      m_wr = m_req & tag;
      n = $countones(m_req & ~tag);
      if (n != 0) m_under = 1;
      m_miss = (m_miss + n > 255) ? 255 : m_miss + n;
      pe = step_acc(0);
      ce = step_acc(1);
      if (m_en == 0) m_req = PMASK;
      else if (lvl >= DEPTH) m_req = '0;
      else if (lvl == 0 || pe != 0) m_req = PMASK;
      else m_req = '0;
      m_cap = (m_en == 0 || ce != 0) ? CMASK : '0;
      if (m_req != 0) play_frames++;
      @(negedge clk);
      frame_start = 1'b0;
      chk({tagr, " flags"}, int'(slot1_flags), flags_of(m_req));
      chk("R10 cap_tag", int'(cap_tag), int'(m_cap));
      chk("R8 fifo_wr", int'(fifo_wr), int'(m_wr));
      chk("R9 underrun", int'(underrun), m_under);
      chk("R9 miss_count", int'(miss_count), m_miss);
      @(negedge clk);
      chk("R8 pulse end", int'(fifo_wr), 0);
   endtask

   function automatic logic [9:0] rnd_tag();
      logic [9:0] t = m_req | 10'($urandom_range(0, 1023) & 10'h3FC);
      if ($urandom_range(0, 7) == 0) t[$urandom_range(0, 1)] = 1'b0;
      return t;
   endfunction

   function automatic int rnd_lvl();
      case ($urandom_range(0, 5))
         0: return 0;
         1: return DEPTH;
         default: return $urandom_range(1, DEPTH - 1);
      endcase
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 enable", int'(var_rate_en), 0);
      chk("R1 dac_rate", int'(dac_rate), BASE);
      chk("R1 adc_rate", int'(adc_rate), BASE);
      chk("R1 flags", int'(slot1_flags), 32'h00FFC);
      chk("R1 cap_tag", int'(cap_tag), 0);
      chk("R1 underrun", int'(underrun), 0);
      chk("R1 miss_count", int'(miss_count), 0);

      // R2 fixed rate ignores FIFO level
      frame(10'h3FF, DEPTH, "R2");
      frame(10'h3FF, 0, "R2");
      for (int i = 0; i < 6; i++) frame(10'h3FF, rnd_lvl(), "R2");

      // R3 rate writes ignored while disabled
      write(2'd1, 11025);
      chk("R3 dac ignored", int'(dac_rate), BASE);
      write(2'd2, 8000);
      chk("R3 adc ignored", int'(adc_rate), BASE);

      // R4 rate programming and clamping
      write(2'd0, 1);
      chk("R4 enable", int'(var_rate_en), 1);
      write(2'd1, 60000);
      chk("R4 clamp", int'(dac_rate), BASE);
      write(2'd1, 44100);
      write(2'd2, 11025);
      chk("R4 dac_rate", int'(dac_rate), 44100);
      chk("R4 adc_rate", int'(adc_rate), 11025);

      // R5/R7/R10 random frames
      for (int i = 0; i < 400; i++) frame(rnd_tag(), rnd_lvl(), "R5 R7");

      // R5 full rate requests every frame at mid level
      write(2'd1, BASE);
      play_frames = 0;
      for (int i = 0; i < 10; i++) frame(m_req, 8, "R5 full rate");
      chk("R5 every frame", play_frames, 10);

      // R5 zero rate never requests unless empty
      write(2'd1, 0);
      play_frames = 0;
      for (int i = 0; i < 10; i++) frame(m_req, 8, "R5 zero rate");
      chk("R5 never", play_frames, 0);
      frame(m_req, 0, "R7 empty forces");
      chk("R7 empty request", int'(slot1_flags), flags_of(PMASK));

      // R8 tags on unrequested slots, R9 missed tags
      write(2'd1, 24000);
      for (int i = 0; i < 8; i++) frame(10'h3FC, 8, "R9 miss");
      frame(10'h3FF, DEPTH, "R7 full blocks");
      chk("R7 no request", int'(slot1_flags), 32'h00FFC);
      frame(10'h3FF, 8, "R8 unrequested tags");

      // back to disabled: rates forced
      write(2'd0, 0);
      chk("R3 forced dac", int'(dac_rate), BASE);
      chk("R3 forced adc", int'(adc_rate), BASE);
      for (int i = 0; i < 40; i++) frame(rnd_tag(), rnd_lvl(), "R2 again");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule